// File: doc/BRIEF.md
# Shrinking-Width XOR Parity Stripe Manager

This block keeps a parity stripe over up to `N_MAX` data members plus one parity member. The stripe starts with a strobe and one data word is then written for each active member, in any order. The block folds each word into a running XOR. After the last active word it presents the parity word for a single cycle. Words addressed to members that have been retired do not enter the parity.

When a member is reported as uncorrectable, the block retires it for good and the active data count drops by one. It then enters a rebuild phase. In that phase the caller streams the surviving data words and the stripe parity, and the block XORs them to regenerate the lost member. The result appears on a spare-region output. The count never falls below `N_MIN`. A failure report at that floor sets a sticky fatal flag. A failure report that arrives while a rebuild is still running is refused and sets a sticky reject flag.

Top module: `psg_group_mgr`

## Requirements
- R1: `parity_valid` pulses in the cycle after the word that brings the number of accepted data words in the current stripe up to `group_size`. `parity_data` is then the XOR of exactly those words, and further words in the same stripe are ignored.
- R2: `stripe_start` discards any partial accumulation. A word written in the same cycle as `stripe_start` is the first word of the new stripe. No word is accepted before the first `stripe_start` after reset.
- R3: A write whose `wr_member` names a retired member, or an index of `N_MAX` or more, has no effect on the parity or on the word count.
- R4: After reset, `group_size` equals `N_MAX`, and `parity_valid`, `spare_valid`, `rebuild_busy`, `fatal_err` and `reject_err` are all 0.
- R5: A failure report (`fail_valid`) for an active member, made while no rebuild runs and while `group_size` exceeds `N_MIN`, retires that member. In the next cycle `group_size` is one lower and `rebuild_busy` is 1.
- R6: During a rebuild, the first `group_size`+1 words on `rb_valid`/`rb_data` are XORed together. `spare_valid` pulses with that XOR in the cycle after the last of those words, and `rebuild_busy` falls one cycle later.
- R7: A failure report for an active member while `group_size` equals `N_MIN` and no rebuild runs sets `fatal_err`, which stays set until reset. `group_size` does not change.
- R8: A failure report while `rebuild_busy` is 1 sets `reject_err`, which stays set until reset. It retires nothing, and `group_size` does not change.
- R9: A failure report for a member that is already retired changes nothing. It neither starts a rebuild nor sets an error flag.
- R10: `group_size` never falls below `N_MIN`, and it changes by at most one step down per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stripe_start | input | 1 | Begins a new stripe accumulation |
| wr_valid | input | 1 | Data word present |
| wr_member | input | IDXW | Member index of the data word |
| wr_data | input | W | Data word |
| parity_valid | output | 1 | Parity word valid, one-cycle pulse |
| parity_data | output | W | Stripe parity |
| fail_valid | input | 1 | Uncorrectable-member report |
| fail_member | input | IDXW | Index of the reported member |
| rb_valid | input | 1 | Survivor or parity word for rebuild |
| rb_data | input | W | Rebuild input word |
| spare_valid | output | 1 | Reconstructed word valid, one-cycle pulse |
| spare_data | output | W | Reconstructed member content |
| rebuild_busy | output | 1 | Rebuild in progress |
| group_size | output | CW | Current active data member count |
| fatal_err | output | 1 | Sticky: failure at the minimum group size |
| reject_err | output | 1 | Sticky: failure during a rebuild |

## Verification
The bench writes stripes in scrambled member order. It restarts a stripe partway through, which a design that kept stale XOR state would fail with a wrong parity word. It interleaves writes to a retired member inside a stripe: a design that still counted them would emit parity early, and one that still XORed them would emit a wrong value. It retires members one at a time until the floor is reached. At each step it checks that the rebuild waits for the shrunken count plus one words. Finally it fires repeated, retired-member, floor-level and mid-rebuild failure reports. A design that shrank twice, restarted a rebuild or left an error flag unset would show a wrong `group_size` or a missing flag.

// File: rtl/psg_pkg.sv
package psg_pkg;
  function automatic int unsigned count_ones(input logic [63:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < n; i++) c += v[i] ? 1 : 0;
    return c;
  endfunction
endpackage

// File: rtl/psg_xor_acc.sv
module psg_xor_acc #(
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [CW-1:0] target,
  output logic          out_valid,
  output logic [W-1:0]  out_data
);
  logic [W-1:0]  acc_q, acc_n, base_acc;
  logic [CW-1:0] cnt_q, cnt_n, base_cnt;
  logic          done_q, done_n, base_done, take, hit;

  always_comb begin
    base_acc  = start ? '0 : acc_q;
    base_cnt  = start ? '0 : cnt_q;
    base_done = start ? 1'b0 : done_q;
    take      = in_valid & ~base_done;
    acc_n     = take ? (base_acc ^ in_data) : base_acc;
    cnt_n     = base_cnt + CW'(take);
    hit       = take && (cnt_n == target);
    done_n    = base_done | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      acc_q     <= acc_n;
      cnt_q     <= cnt_n;
      done_q    <= done_n;
      out_valid <= hit;
      if (hit) out_data <= acc_n;
    end
  end

  p_out_follows_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
endmodule

// File: rtl/psg_member_track.sv
module psg_member_track
  import psg_pkg::*;
#(
  parameter int N_MAX = 4,
  parameter int N_MIN = 2,
  parameter int IDXW  = 2,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_valid,
  input  logic [IDXW-1:0]  fail_member,
  input  logic             rebuild_done,
  output logic [N_MAX-1:0] broken,
  output logic [CW-1:0]    size,
  output logic             accept,
  output logic             busy,
  output logic             fatal_err,
  output logic             reject_err
);
  localparam logic [CW-1:0] MIN_C = CW'(N_MIN);
  localparam logic [CW-1:0] MAX_C = CW'(N_MAX);

  logic [N_MAX-1:0] broken_n;
  logic             busy_n, fatal_n, reject_n, idx_ok, is_active, at_floor;

  always_comb begin
    size      = MAX_C - CW'(count_ones(64'(broken), N_MAX));
    idx_ok    = (32'(fail_member) < N_MAX);
    is_active = idx_ok && !broken[fail_member];
    at_floor  = (size <= MIN_C);
    accept    = fail_valid && !busy && is_active && !at_floor;
    broken_n  = broken;
    if (accept) broken_n[fail_member] = 1'b1;
    busy_n    = accept ? 1'b1 : (rebuild_done ? 1'b0 : busy);
    fatal_n   = fatal_err  | (fail_valid && !busy && is_active && at_floor);
    reject_n  = reject_err | (fail_valid && busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      broken     <= '0;
      busy       <= 1'b0;
      fatal_err  <= 1'b0;
      reject_err <= 1'b0;
    end else begin
      broken     <= broken_n;
      busy       <= busy_n;
      fatal_err  <= fatal_n;
      reject_err <= reject_n;
    end
  end

  p_size_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    size >= MIN_C);
  p_size_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (size == $past(size)) || (size + CW'(1) == $past(size)));
  p_fatal_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);
  p_reject_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_err |=> reject_err);
  p_busy_keeps_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(size));
endmodule

// File: rtl/psg_group_mgr.sv
module psg_group_mgr #(
  parameter int W     = 16,
  parameter int N_MAX = 4,
  parameter int N_MIN = 2,
  localparam int IDXW = (N_MAX > 1) ? $clog2(N_MAX) : 1,
  localparam int CW   = $clog2(N_MAX + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stripe_start,
  input  logic            wr_valid,
  input  logic [IDXW-1:0] wr_member,
  input  logic [W-1:0]    wr_data,
  output logic            parity_valid,
  output logic [W-1:0]    parity_data,
  input  logic            fail_valid,
  input  logic [IDXW-1:0] fail_member,
  input  logic            rb_valid,
  input  logic [W-1:0]    rb_data,
  output logic            spare_valid,
  output logic [W-1:0]    spare_data,
  output logic            rebuild_busy,
  output logic [CW-1:0]   group_size,
  output logic            fatal_err,
  output logic            reject_err
);
  logic [N_MAX-1:0] broken;
  logic             accept, wr_take, rb_take;
  logic [CW-1:0]    rb_target;

  psg_member_track #(.N_MAX(N_MAX), .N_MIN(N_MIN), .IDXW(IDXW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_member(fail_member),
    .rebuild_done(spare_valid), .broken(broken), .size(group_size), .accept(accept),
    .busy(rebuild_busy), .fatal_err(fatal_err), .reject_err(reject_err));

  always_comb begin
    wr_take   = wr_valid && (32'(wr_member) < N_MAX) && !broken[wr_member];
    rb_take   = rb_valid && rebuild_busy;
    rb_target = group_size + CW'(1);
  end

  psg_xor_acc #(.W(W), .CW(CW)) u_parity (
    .clk(clk), .rst_n(rst_n), .start(stripe_start), .in_valid(wr_take),
    .in_data(wr_data), .target(group_size), .out_valid(parity_valid), .out_data(parity_data));

  psg_xor_acc #(.W(W), .CW(CW)) u_rebuild (
    .clk(clk), .rst_n(rst_n), .start(accept), .in_valid(rb_take),
    .in_data(rb_data), .target(rb_target), .out_valid(spare_valid), .out_data(spare_data));

  p_spare_in_rebuild_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spare_valid |-> rebuild_busy);
  p_shrink_starts_rebuild_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (group_size + CW'(1) == $past(group_size)) |-> rebuild_busy);
endmodule

// File: tb/tb_psg_group_mgr.sv
`timescale 1ns/1ps
module tb_psg_group_mgr;
  localparam int W = 16;
  localparam int N_MAX = 4;
  localparam int N_MIN = 2;

  logic clk, rst_n, stripe_start, wr_valid, fail_valid, rb_valid;
  logic [1:0] wr_member, fail_member;
  logic [W-1:0] wr_data, rb_data;
  logic parity_valid, spare_valid, rebuild_busy, fatal_err, reject_err;
  logic [W-1:0] parity_data, spare_data;
  logic [2:0] group_size;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] par_q[$];
  logic [W-1:0] spr_q[$];

  psg_group_mgr #(.W(W), .N_MAX(N_MAX), .N_MIN(N_MIN)) dut (
    .clk(clk), .rst_n(rst_n), .stripe_start(stripe_start), .wr_valid(wr_valid),
    .wr_member(wr_member), .wr_data(wr_data), .parity_valid(parity_valid),
    .parity_data(parity_data), .fail_valid(fail_valid), .fail_member(fail_member),
    .rb_valid(rb_valid), .rb_data(rb_data), .spare_valid(spare_valid),
    .spare_data(spare_data), .rebuild_busy(rebuild_busy), .group_size(group_size),
    .fatal_err(fatal_err), .reject_err(reject_err));

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares produced words with scoreboard queues
  always @(negedge clk) begin
    if (rst_n && parity_valid) begin
      if (par_q.size() == 0) check("R1 unexpected parity", 32'(parity_data), 32'hDEAD);
      else check("R1 parity word", 32'(parity_data), 32'(par_q.pop_front()));
    end
    if (rst_n && spare_valid) begin
      if (spr_q.size() == 0) check("R6 unexpected spare", 32'(spare_data), 32'hDEAD);
      else check("R6 spare word", 32'(spare_data), 32'(spr_q.pop_front()));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    stripe_start = 0; wr_valid = 0; fail_valid = 0; rb_valid = 0;
  endtask

  task automatic wr(bit st, int m, logic [W-1:0] d);
    stripe_start = st; wr_valid = 1; wr_member = 2'(m); wr_data = d;
    tick();
  endtask

  task automatic rb(logic [W-1:0] d);
    rb_valid = 1; rb_data = d;
    tick();
  endtask

  task automatic fail(int m);
    fail_valid = 1; fail_member = 2'(m);
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; stripe_start = 0; wr_valid = 0; fail_valid = 0; rb_valid = 0;
    wr_member = 0; fail_member = 0; wr_data = 0; rb_data = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    // R4 reset state
    check("R4 group_size", 32'(group_size), 4);
    check("R4 busy", 32'(rebuild_busy), 0);
    check("R4 fatal", 32'(fatal_err), 0);
    check("R4 reject", 32'(reject_err), 0);
    check("R4 valids", {parity_valid, spare_valid}, 0);
    @(posedge clk); #1;
    // R2 words before first start are ignored
    for (int i = 0; i < 4; i++) wr(0, i, 16'h1111);
    idle(2);
    // R1 in-order stripe
    par_q.push_back(16'h1234 ^ 16'h00FF ^ 16'hA5A5 ^ 16'h0F0F);
    wr(1, 0, 16'h1234); wr(0, 1, 16'h00FF); wr(0, 2, 16'hA5A5); wr(0, 3, 16'h0F0F);
    // R1 extra word after completion is ignored
    wr(0, 0, 16'hFFFF);
    idle(2);
    // R1 scrambled order
    par_q.push_back(16'h8001 ^ 16'h4002 ^ 16'h2004 ^ 16'h1008);
    wr(1, 2, 16'h8001); wr(0, 0, 16'h4002); wr(0, 3, 16'h2004); wr(0, 1, 16'h1008);
    idle(2);
    // R2 restart discards partial stripe
    wr(1, 0, 16'hBEEF); wr(0, 1, 16'hCAFE);
    par_q.push_back(16'h0001 ^ 16'h0010 ^ 16'h0100 ^ 16'h1000);
    wr(1, 3, 16'h0001); wr(0, 2, 16'h0010); wr(0, 1, 16'h0100); wr(0, 0, 16'h1000);
    idle(2);
    // R5 retire member 1
    fail(1);
    @(negedge clk);
    check("R5 group_size after fail", 32'(group_size), 3);
    check("R5 busy", 32'(rebuild_busy), 1);
    @(posedge clk); #1;
    // R6 rebuild: 3 survivors + parity; R8 failure mid-rebuild rejected
    spr_q.push_back(16'h1357 ^ 16'h2468 ^ 16'hF00D ^ 16'h7777);
    rb(16'h1357);
    fail(2);
    @(negedge clk);
    check("R8 reject set", 32'(reject_err), 1);
    check("R8 size held", 32'(group_size), 3);
    @(posedge clk); #1;
    rb(16'h2468); rb(16'hF00D); rb(16'h7777);
    rb(16'h9999); // beyond target, ignored
    idle(2);
    @(negedge clk);
    check("R6 busy cleared", 32'(rebuild_busy), 0);
    check("R8 reject sticky", 32'(reject_err), 1);
    @(posedge clk); #1;
    // R3 writes to retired member 1 ignored
    par_q.push_back(16'h0A0A ^ 16'h00B0 ^ 16'hC000);
    wr(1, 0, 16'h0A0A); wr(0, 1, 16'hFFFF); wr(0, 2, 16'h00B0); wr(0, 1, 16'h1234);
    wr(0, 3, 16'hC000);
    idle(2);
    // R9 repeated failure of retired member
    fail(1);
    @(negedge clk);
    check("R9 size unchanged", 32'(group_size), 3);
    check("R9 no rebuild", 32'(rebuild_busy), 0);
    check("R9 no fatal", 32'(fatal_err), 0);
    @(posedge clk); #1;
    // R5 second shrink to floor, R6 rebuild of 3 words
    fail(0);
    @(negedge clk);
    check("R5 group_size to floor", 32'(group_size), 2);
    @(posedge clk); #1;
    spr_q.push_back(16'h0102 ^ 16'h0304 ^ 16'h0506);
    rb(16'h0102); rb(16'h0304); rb(16'h0506);
    idle(3);
    // R1 stripe with two active members
    par_q.push_back(16'h5555 ^ 16'h3333);
    wr(1, 3, 16'h5555); wr(0, 0, 16'hAAAA); wr(0, 2, 16'h3333);
    idle(2);
    // R7 failure at floor
    fail(3);
    @(negedge clk);
    check("R7 fatal set", 32'(fatal_err), 1);
    check("R7 size held", 32'(group_size), 2);
    check("R7 no rebuild", 32'(rebuild_busy), 0);
    check("R10 size at floor", 32'(group_size >= 3'(N_MIN)), 1);
    @(posedge clk); #1;
    idle(3);
    check("R7 fatal sticky", 32'(fatal_err), 1);
    check("R1 parity words all seen", par_q.size(), 0);
    check("R6 spare words all seen", spr_q.size(), 0);
    finish_run();
  end
endmodule